// File: doc/BRIEF.md
# Packed SIMD Execution Fault Arbiter

This block decides, for one packed-integer SIMD operation at a time, whether the operation may go ahead or must trap. The issue stage presents a set of inputs together with a one-cycle `checkReq` pulse:

- the processor mode;
- the feature word and which SIMD generation the operation belongs to;
- the floating-point emulation, task-switched and OS save/restore control bits;
- whether the operation reads memory, and whether it is the byte-mask extraction form;
- the low address bits and the stack-relative flag;
- the misaligned-access mode bit and alignment-check enable;
- the limit, canonical, null-segment and page-fault status from the address unit.

On the next cycle the block drives either a `go` pulse or a single prioritised exception code.

The address unit stays outside this block; only its verdicts come in. Some exception classes depend on the processor mode. A misaligned 16-byte access becomes a general-protection fault when the misaligned mode is off. When that mode is on, and alignment checking is enabled, it becomes an alignment-check exception.

Top module: `vecTrapCheck`

## Requirements
- R1: While `rstN` is low, `excCode` is 0 and `go` is 0.
- R2: The result appears exactly one cycle after a cycle with `checkReq` high. In that cycle `go` is 1 if and only if `excCode` is 0. In every other cycle both outputs are 0. Codes are: 0 none, 1 invalid opcode, 2 device not available, 3 stack fault, 4 general protection, 5 page fault, 6 alignment check.
- R3: Code 1 is raised in any of these cases: the required feature bit is 0 (bit 25 of `featWord` when `newGen` is 0, bit 26 when `newGen` is 1); `emulateBit` is 1; `osSaveEn` is 0.
- R4: `taskSwitched` at 1 raises code 2.
- R5: A memory access with `stackRel` at 1 and either `segLimitViol` or `nonCanon` set raises code 3.
- R6: A memory access with `stackRel` at 0 and either `segLimitViol` or `nonCanon` set raises code 4. So does `nullSeg` in protected mode (`cpuMode` 2 or 3). `nullSeg` is ignored in real mode (0) and virtual-8086 mode (1).
- R7: With `misalignMode` at 0, a memory access whose `addrLow` is nonzero raises code 4 in real and protected mode. It does not do so in virtual-8086 mode.
- R8: `pageFault` raises code 5 in virtual-8086 and protected mode and is ignored in real mode.
- R9: With `misalignMode` at 1 and `alignChkEn` at 1, a memory access whose `addrLow` is nonzero raises code 6 in virtual-8086 and protected mode. It does not do so in real mode.
- R10: When `hasMemOp` is 0 or `maskExtract` is 1, codes 3 to 6 are never produced.
- R11: When several conditions hold, the code reported is the lowest nonzero one: 1 before 2 before 3 before 4 before 5 before 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| checkReq | input | 1 | Evaluate the presented operation this cycle |
| cpuMode | input | 2 | 0 real, 1 virtual-8086, 2 or 3 protected |
| newGen | input | 1 | Operation belongs to the newer SIMD generation |
| featWord | input | 32 | Processor feature word |
| emulateBit | input | 1 | Floating-point emulation control bit |
| taskSwitched | input | 1 | Task-switched control bit |
| osSaveEn | input | 1 | OS supports SIMD state save/restore |
| hasMemOp | input | 1 | Operation has a memory operand |
| maskExtract | input | 1 | Operation is the byte-mask extraction form |
| stackRel | input | 1 | Memory address is stack-relative |
| addrLow | input | 4 | Low address bits of the memory operand |
| misalignMode | input | 1 | Misaligned-access mode control bit |
| alignChkEn | input | 1 | Alignment checking enabled |
| segLimitViol | input | 1 | Address exceeds its segment limit |
| nonCanon | input | 1 | Address is non-canonical |
| nullSeg | input | 1 | A null data segment was used |
| pageFault | input | 1 | Translation reported a page fault |
| excCode | output | 3 | Prioritised exception code, valid one cycle after `checkReq` |
| go | output | 1 | Operation may execute, one cycle after `checkReq` |

## Verification
The bench targets the following corner cases:

- **Feature-bit choice.** The two generations are given feature words in which only the other generation's bit is set. A design that tests the wrong bit lets the operation go.
- **Mode-gated causes.** A null segment in virtual-8086 mode, a misaligned access in virtual-8086 mode with the misaligned mode off, and page or alignment faults in real mode must all yield `go`. A design missing the mode gate traps spuriously.
- **Priority collisions.** The bench stacks several causes together, such as a stack fault with a page fault, and misalignment with a page fault under each setting of the misaligned mode. A design with the order wrong reports the lower-priority code.
- **Exempt operations.** Register-only and mask-extraction operations are presented with every address fault raised. A design that ignores the exemption reports a memory fault.

// File: rtl/vecTrapPkg.sv
package vecTrapPkg;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_UD   = 3'd1,
    EXC_NM   = 3'd2,
    EXC_SS   = 3'd3,
    EXC_GP   = 3'd4,
    EXC_PF   = 3'd5,
    EXC_AC   = 3'd6
  } excCode_e;

  typedef enum logic [1:0] {
    MODE_REAL  = 2'd0,
    MODE_V86   = 2'd1,
    MODE_PROT  = 2'd2,
    MODE_PROT2 = 2'd3
  } cpuMode_e;

  // Number of exception classes; class index i maps to code i+1,
  // lower index has higher priority.
  localparam int NUM_CLS = 6;
  localparam int CODE_W  = 3;

  typedef struct packed {
    logic               load;
    logic [NUM_CLS-1:0] grant;
  } trapStrobe_t;

endpackage

// File: rtl/vecTrapCond.sv
module vecTrapCond
  import vecTrapPkg::*;
#(
  parameter int FEAT_W     = 32,
  parameter int OLD_BIT    = 25,
  parameter int NEW_BIT    = 26,
  parameter int ALIGN_BITS = 4
) (
  input  logic [1:0]            cpuMode,
  input  logic                  newGen,
  input  logic [FEAT_W-1:0]     featWord,
  input  logic                  emulateBit,
  input  logic                  taskSwitched,
  input  logic                  osSaveEn,
  input  logic                  hasMemOp,
  input  logic                  maskExtract,
  input  logic                  stackRel,
  input  logic [ALIGN_BITS-1:0] addrLow,
  input  logic                  misalignMode,
  input  logic                  alignChkEn,
  input  logic                  segLimitViol,
  input  logic                  nonCanon,
  input  logic                  nullSeg,
  input  logic                  pageFault,
  output logic [NUM_CLS-1:0]    raise
);

  localparam int IDX_W = (FEAT_W > 1) ? $clog2(FEAT_W) : 1;
  localparam logic [IDX_W-1:0] OLD_IDX = IDX_W'(OLD_BIT);
  localparam logic [IDX_W-1:0] NEW_IDX = IDX_W'(NEW_BIT);

  cpuMode_e   modeSel;
  logic       inReal, inV86, inProt;
  logic [IDX_W-1:0] featIdx;
  logic       featOk;
  logic       memLive;
  logic       unaligned;
  logic       addrBad;
  logic       gpAddr, gpNull, gpAlign;

  always_comb begin
    modeSel = cpuMode_e'(cpuMode);
    inReal  = (modeSel == MODE_REAL);
    inV86   = (modeSel == MODE_V86);
    inProt  = (modeSel == MODE_PROT) || (modeSel == MODE_PROT2);
  end

  assign featIdx   = newGen ? NEW_IDX : OLD_IDX;
  assign featOk    = featWord[featIdx];
  assign memLive   = hasMemOp && !maskExtract;
  assign unaligned = |addrLow;
  assign addrBad   = segLimitViol || nonCanon;

  assign gpAddr  = !stackRel && addrBad;
  assign gpNull  = inProt && nullSeg;
  assign gpAlign = !misalignMode && unaligned && (inReal || inProt);

  always_comb begin
    raise    = '0;
    raise[0] = !featOk || emulateBit || !osSaveEn;
    raise[1] = taskSwitched;
    raise[2] = memLive && stackRel && addrBad;
    raise[3] = memLive && (gpAddr || gpNull || gpAlign);
    raise[4] = memLive && pageFault && (inV86 || inProt);
    raise[5] = memLive && misalignMode && alignChkEn && unaligned && (inV86 || inProt);
  end

endmodule

// File: rtl/vecTrapCtrl.sv
module vecTrapCtrl
  import vecTrapPkg::*;
(
  input  logic               checkReq,
  input  logic [NUM_CLS-1:0] raise,
  output trapStrobe_t        strobe
);

  logic [NUM_CLS-1:0] grantVec;
  logic               taken;

  always_comb begin
    grantVec = '0;
    taken    = 1'b0;
    for (int i = 0; i < NUM_CLS; i++) begin
      if (raise[i] && !taken) begin
        grantVec[i] = 1'b1;
        taken       = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load  = checkReq;
    strobe.grant = checkReq ? grantVec : '0;
  end

endmodule

// File: rtl/vecTrapRegs.sv
module vecTrapRegs
  import vecTrapPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobe_t       strobe,
  output logic [CODE_W-1:0] excCode,
  output logic              go
);

  logic [CODE_W-1:0] codeNext;
  logic [CODE_W-1:0] codeTerm [NUM_CLS];

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_enc
    assign codeTerm[g] = strobe.grant[g] ? CODE_W'(g + 1) : '0;
  end

  always_comb begin
    codeNext = '0;
    for (int i = 0; i < NUM_CLS; i++) codeNext = codeNext | codeTerm[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excCode <= '0;
      go      <= 1'b0;
    end else begin
      excCode <= strobe.load ? codeNext : '0;
      go      <= strobe.load && (strobe.grant == '0);
    end
  end

endmodule

// File: rtl/vecTrapCheck.sv
module vecTrapCheck
  import vecTrapPkg::*;
#(
  parameter int FEAT_W     = 32,
  parameter int OLD_BIT    = 25,
  parameter int NEW_BIT    = 26,
  parameter int ALIGN_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  checkReq,
  input  logic [1:0]            cpuMode,
  input  logic                  newGen,
  input  logic [FEAT_W-1:0]     featWord,
  input  logic                  emulateBit,
  input  logic                  taskSwitched,
  input  logic                  osSaveEn,
  input  logic                  hasMemOp,
  input  logic                  maskExtract,
  input  logic                  stackRel,
  input  logic [ALIGN_BITS-1:0] addrLow,
  input  logic                  misalignMode,
  input  logic                  alignChkEn,
  input  logic                  segLimitViol,
  input  logic                  nonCanon,
  input  logic                  nullSeg,
  input  logic                  pageFault,
  output logic [2:0]            excCode,
  output logic                  go
);

  logic [NUM_CLS-1:0] raise;
  trapStrobe_t        strobe;

  vecTrapCond #(
    .FEAT_W(FEAT_W), .OLD_BIT(OLD_BIT), .NEW_BIT(NEW_BIT), .ALIGN_BITS(ALIGN_BITS)
  ) i_cond (
    .cpuMode(cpuMode), .newGen(newGen), .featWord(featWord),
    .emulateBit(emulateBit), .taskSwitched(taskSwitched), .osSaveEn(osSaveEn),
    .hasMemOp(hasMemOp), .maskExtract(maskExtract), .stackRel(stackRel),
    .addrLow(addrLow), .misalignMode(misalignMode), .alignChkEn(alignChkEn),
    .segLimitViol(segLimitViol), .nonCanon(nonCanon), .nullSeg(nullSeg),
    .pageFault(pageFault), .raise(raise)
  );

  vecTrapCtrl i_ctrl (
    .checkReq(checkReq), .raise(raise), .strobe(strobe)
  );

  vecTrapRegs i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .excCode(excCode), .go(go)
  );

endmodule

// File: rtl/vecTrapSva.sv
module vecTrapSva (
  input logic       clk,
  input logic       rstN,
  input logic       checkReq,
  input logic [1:0] cpuMode,
  input logic       emulateBit,
  input logic       taskSwitched,
  input logic       hasMemOp,
  input logic       maskExtract,
  input logic [2:0] excCode,
  input logic       go
);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(checkReq) |-> (excCode == 3'd0 && !go));

  // R2
  go_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    go |-> (excCode == 3'd0));

  // R2
  resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && checkReq) |-> (go || excCode != 3'd0));

  // R3
  emu_ud_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && checkReq && emulateBit) |-> (excCode == 3'd1));

  // R4
  ts_nm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && checkReq && taskSwitched) |-> (excCode == 3'd1 || excCode == 3'd2));

  // R10
  no_mem_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && checkReq && (!hasMemOp || maskExtract)) |-> (excCode <= 3'd2));

  // R8
  real_no_pf_ac_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && checkReq && cpuMode == 2'd0) |-> (excCode != 3'd5 && excCode != 3'd6));

endmodule

bind vecTrapCheck vecTrapSva i_sva (.*);

// File: tb/test_vecTrapCheck.sv
module test_vecTrapCheck;

  logic        clk = 1'b0;
  logic        rstN;
  logic        checkReq;
  logic [1:0]  cpuMode;
  logic        newGen;
  logic [31:0] featWord;
  logic        emulateBit, taskSwitched, osSaveEn;
  logic        hasMemOp, maskExtract, stackRel;
  logic [3:0]  addrLow;
  logic        misalignMode, alignChkEn;
  logic        segLimitViol, nonCanon, nullSeg, pageFault;
  logic [2:0]  excCode;
  logic        go;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vecTrapCheck i_vecTrapCheck (.*);

  // Behavioural reference: first matching cause wins.
  function automatic int refCode();
    bit featOk = newGen ? featWord[26] : featWord[25];
    bit mem    = hasMemOp && !maskExtract;
    bit isReal = (cpuMode == 2'd0);
    bit isV86  = (cpuMode == 2'd1);
    bit isProt = (cpuMode >= 2'd2);
    bit unal   = (addrLow != 4'd0);
    if (!featOk || emulateBit || !osSaveEn) return 1;
    if (taskSwitched) return 2;
    if (!mem) return 0;
    if (stackRel && (segLimitViol || nonCanon)) return 3;
    if (!stackRel && (segLimitViol || nonCanon)) return 4;
    if (isProt && nullSeg) return 4;
    if (!misalignMode && unal && !isV86) return 4;
    if (pageFault && !isReal) return 5;
    if (misalignMode && alignChkEn && unal && !isReal) return 6;
    return 0;
  endfunction

  function automatic string tagFor(int c);
    case (c)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R8";
      6: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic tick(input string tag);
    int expCode = checkReq ? refCode() : 0;
    bit expGo   = checkReq && (expCode == 0);
    @(negedge clk);
    checks++;
    if (excCode != 3'(expCode) || go != expGo) begin
      errors++;
      $display("FAIL %s: code=%0d go=%0d expected code=%0d go=%0d",
               tag, excCode, go, expCode, expGo);
    end
  endtask

  task automatic setClean();
    checkReq = 1; cpuMode = 2'd2; newGen = 1; featWord = 32'h0600_0000;
    emulateBit = 0; taskSwitched = 0; osSaveEn = 1;
    hasMemOp = 1; maskExtract = 0; stackRel = 0; addrLow = 4'd0;
    misalignMode = 0; alignChkEn = 0;
    segLimitViol = 0; nonCanon = 0; nullSeg = 0; pageFault = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    setClean();
    rstN = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (excCode != 3'd0 || go != 1'b0) begin
      errors++;
      $display("FAIL R1: code=%0d go=%0d expected code=0 go=0", excCode, go);
    end
    rstN = 1;

    setClean(); tick("R2");
    setClean(); checkReq = 0; pageFault = 1; taskSwitched = 1; tick("R2");
    setClean(); featWord = 32'h0200_0000; tick("R3");
    setClean(); newGen = 0; featWord = 32'h0400_0000; tick("R3");
    setClean(); newGen = 0; featWord = 32'h0200_0000; tick("R3");
    setClean(); emulateBit = 1; tick("R3");
    setClean(); osSaveEn = 0; tick("R3");
    setClean(); taskSwitched = 1; tick("R4");
    setClean(); taskSwitched = 1; emulateBit = 1; tick("R11");
    setClean(); stackRel = 1; segLimitViol = 1; tick("R5");
    setClean(); stackRel = 1; nonCanon = 1; pageFault = 1; tick("R11");
    setClean(); nonCanon = 1; tick("R6");
    setClean(); nullSeg = 1; tick("R6");
    setClean(); nullSeg = 1; cpuMode = 2'd3; tick("R6");
    setClean(); nullSeg = 1; cpuMode = 2'd1; tick("R6");
    setClean(); nullSeg = 1; cpuMode = 2'd0; tick("R6");
    setClean(); addrLow = 4'd4; cpuMode = 2'd0; tick("R7");
    setClean(); addrLow = 4'd4; cpuMode = 2'd1; tick("R7");
    setClean(); pageFault = 1; tick("R8");
    setClean(); pageFault = 1; cpuMode = 2'd0; tick("R8");
    setClean(); misalignMode = 1; alignChkEn = 1; addrLow = 4'd8; cpuMode = 2'd1; tick("R9");
    setClean(); misalignMode = 1; alignChkEn = 1; addrLow = 4'd8; cpuMode = 2'd0; tick("R9");
    setClean(); misalignMode = 1; alignChkEn = 0; addrLow = 4'd8; tick("R9");
    setClean(); misalignMode = 1; alignChkEn = 1; addrLow = 4'd1; pageFault = 1; tick("R11");
    setClean(); addrLow = 4'd2; pageFault = 1; tick("R11");
    setClean(); hasMemOp = 0; segLimitViol = 1; nullSeg = 1; pageFault = 1; addrLow = 4'd3; tick("R10");
    setClean(); maskExtract = 1; stackRel = 1; nonCanon = 1; pageFault = 1; addrLow = 4'd5; tick("R10");
    setClean(); maskExtract = 1; taskSwitched = 1; tick("R10");

    for (int n = 0; n < 3000; n++) begin
      int pick;
      checkReq     = ($urandom_range(0, 7) != 0);
      cpuMode      = 2'($urandom_range(0, 3));
      newGen       = 1'($urandom_range(0, 1));
      featWord     = ($urandom_range(0, 7) == 0) ? $urandom() : 32'h0600_0000;
      emulateBit   = ($urandom_range(0, 15) == 0);
      taskSwitched = ($urandom_range(0, 15) == 0);
      osSaveEn     = ($urandom_range(0, 15) != 0);
      hasMemOp     = 1'($urandom_range(0, 1));
      maskExtract  = ($urandom_range(0, 7) == 0);
      stackRel     = 1'($urandom_range(0, 1));
      addrLow      = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
      misalignMode = 1'($urandom_range(0, 1));
      alignChkEn   = 1'($urandom_range(0, 1));
      segLimitViol = ($urandom_range(0, 7) == 0);
      nonCanon     = ($urandom_range(0, 7) == 0);
      nullSeg      = ($urandom_range(0, 7) == 0);
      pageFault    = ($urandom_range(0, 3) == 0);
      pick = checkReq ? refCode() : 0;
      tick(tagFor(pick));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule